// File: doc/BRIEF.md
# Disk Address Check and Advance Unit

This unit takes an 18-bit packed disk address (cylinder, surface and sector fields), range-checks each field against the geometry of the selected drive, and converts the address to a linear sector index. It also takes the number of words a transfer will move. From these it computes the address at which the next transfer should start. The drive is one of two sizes. A per-request flag selects the large one. Each sector holds 256 words, each surface has 10 sectors, and each cylinder has 20 surfaces. The small drive has 203 cylinders and the large drive has 406.

The cylinder number is 9 bits wide. Its low 8 bits are at the top of the word, and its ninth bit is a single bit inside the low half of the word. If the transfer would run past the end of the drive, the unit raises an end-of-pack flag and trims the count to the words that remain. The next address is found by rounding the end word up to a whole sector, so a partly filled sector counts as used. That sector number is then split back into fields by a shift-subtract divider. A cylinder that reaches the drive limit wraps to zero.

A request is a one-cycle `start` while the unit is idle. The range flags, the linear index, the end-of-pack flag and the trimmed count appear on the cycle after `start`. The next address appears together with a one-cycle `done`.

Top module: `disk_addr_stepper`

## Requirements
- R1: The fields of `addr_in` are decoded as follows: sector = bits 3..0, surface = bits 9..5, cylinder = bits 17..10 plus 256 when bit 4 is set.
- R2: `sect_err` is 1 exactly when the sector field is 10 or more.
- R3: `surf_err` is 1 exactly when the surface field is 20 or more.
- R4: `cyl_err` is 1 exactly when the cylinder is at or above the limit, which is 203 with `large_drive`=0 and 406 with `large_drive`=1.
- R5: `lin_sector` equals (cylinder*20 + surface)*10 + sector.
- R6: Let the start word be lin_sector*256 and the capacity be limit*200*256. When there is no range error and start word + `word_cnt` exceeds the capacity, `end_of_pack`=1 and `xfer_cnt` = capacity - start word. Otherwise, with no range error, `end_of_pack`=0 and `xfer_cnt`=`word_cnt`.
- R7: With no range error, the final sector number is ceil((start word + `xfer_cnt`)/256). `next_addr` packs that sector number as cylinder = final/200, surface = (final mod 200)/10 and sector = final mod 10, using the R1 layout. Bit 4 is set when the cylinder is 256 or more.
- R8: When the final cylinder equals the drive limit, `next_addr` carries cylinder 0, surface 0 and sector 0.
- R9: When any range flag is set, `next_addr` equals the requested address, `xfer_cnt`=0 and `end_of_pack`=0.
- R10: A `start` that is sampled while idle raises `busy` from the next cycle. `done` is a one-cycle pulse 25 cycles after that `start` edge, and `busy` falls on the same edge that raises `done`. All results hold until the next accepted `start`.
- R11: `start` has no effect while `busy` is 1. The results are those of the request that was already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| large_drive | input | 1 | 1 selects the 406-cylinder drive, 0 the 203-cylinder drive |
| addr_in | input | 18 | Packed disk address |
| word_cnt | input | 18 | Words the transfer will move |
| busy | output | 1 | Divider running |
| done | output | 1 | One-cycle completion pulse |
| sect_err | output | 1 | Sector out of range |
| surf_err | output | 1 | Surface out of range |
| cyl_err | output | 1 | Cylinder out of range for the selected drive |
| lin_sector | output | 17 | Linear sector index of `addr_in` |
| end_of_pack | output | 1 | Transfer trimmed at the end of the drive |
| xfer_cnt | output | 18 | Word count after trimming |
| next_addr | output | 18 | Packed address following the transfer |

## Verification
The assertions on field ranges and cylinder wrap hold for every input value. They rely on the trimming step to keep the final sector number no greater than the capacity in sectors, so they take nothing for granted about `addr_in` or `word_cnt`. The start-ignored property assumes only that `start` may arrive at any time. The stimulus therefore mixes fully random 18-bit addresses and counts, which often break the sector and surface ranges, with addresses kept inside the geometry and addresses on the last cylinder that force trimming and wrap. Directed cases pin the cylinder-256 bit, the exact-fit end of each drive and rounding of a partial sector.

// File: rtl/disk_addr_stepper.sv
module disk_addr_stepper #(
  parameter int WORDS_PER_SECT = 256,
  parameter int SECTS          = 10,
  parameter int SURFS          = 20,
  parameter int CYL_SMALL      = 203,
  parameter int CYL_LARGE      = 406,
  parameter int CNT_W          = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             large_drive,
  input  logic [17:0]      addr_in,
  input  logic [CNT_W-1:0] word_cnt,
  output logic             busy,
  output logic             done,
  output logic             sect_err,
  output logic             surf_err,
  output logic             cyl_err,
  output logic [16:0]      lin_sector,
  output logic             end_of_pack,
  output logic [CNT_W-1:0] xfer_cnt,
  output logic [17:0]      next_addr
);
  localparam int SHW   = $clog2(WORDS_PER_SECT);
  localparam int TRACK = SECTS * SURFS;
  localparam int CYLW  = 9;
  localparam int LINW  = 17;
  localparam int WORDW = LINW + SHW;
  localparam int SUMW  = WORDW + 1;
  localparam int RW    = $clog2(TRACK);
  localparam logic [SUMW-1:0] CAP_S = SUMW'(CYL_SMALL * TRACK * WORDS_PER_SECT);
  localparam logic [SUMW-1:0] CAP_L = SUMW'(CYL_LARGE * TRACK * WORDS_PER_SECT);

  typedef enum logic [1:0] {IDLE, DIV_TRK, DIV_SEC} phase_t;
  phase_t phase;

  // request decode
  logic [CYLW-1:0]  cyl_in, lim_in;
  logic             sect_c, surf_c, cyl_c, err_c, eop_c;
  logic [LINW-1:0]  lin_c, fs_c;
  logic [WORDW-1:0] sw_c;
  logic [SUMW-1:0]  cap_c, sum_c, endw_c;
  logic [CNT_W-1:0] xc_c;

  assign cyl_in = {addr_in[4], addr_in[17:10]};
  assign lim_in = large_drive ? CYLW'(CYL_LARGE) : CYLW'(CYL_SMALL);
  assign sect_c = addr_in[3:0] >= 4'(SECTS);
  assign surf_c = addr_in[9:5] >= 5'(SURFS);
  assign cyl_c  = cyl_in >= lim_in;
  assign err_c  = sect_c | surf_c | cyl_c;
  assign lin_c  = LINW'((32'(cyl_in) * SURFS + 32'(addr_in[9:5])) * SECTS + 32'(addr_in[3:0]));
  assign sw_c   = {lin_c, SHW'(0)};
  assign cap_c  = large_drive ? CAP_L : CAP_S;
  assign sum_c  = SUMW'(sw_c) + SUMW'(word_cnt);
  assign eop_c  = !err_c && (sum_c > cap_c);
  assign xc_c   = err_c ? '0 : (eop_c ? CNT_W'(cap_c - SUMW'(sw_c)) : word_cnt);
  assign endw_c = SUMW'(sw_c) + SUMW'(xc_c);
  assign fs_c   = LINW'((endw_c + SUMW'(WORDS_PER_SECT - 1)) >> SHW);

  // shared shift-subtract divider
  logic [LINW-1:0] dvd, dvd_n;
  logic [RW-1:0]   rem, rem_n;
  logic [RW:0]     trial, dvsr;
  logic            ge;
  logic [4:0]      stepc;
  logic [CYLW-1:0] cyl_q, lim_q, cyl_w;
  logic [17:0]     a_q;
  logic            err_q;

  assign dvsr  = (phase == DIV_SEC) ? (RW+1)'(SECTS) : (RW+1)'(TRACK);
  assign trial = {rem, dvd[LINW-1]};
  assign ge    = trial >= dvsr;
  assign rem_n = ge ? RW'(trial - dvsr) : RW'(trial);
  assign dvd_n = {dvd[LINW-2:0], ge};
  assign cyl_w = (cyl_q >= lim_q) ? '0 : cyl_q;
  assign err_q = sect_err | surf_err | cyl_err;
  assign busy  = phase != IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE; done <= 1'b0; dvd <= '0; rem <= '0; stepc <= '0;
      cyl_q <= '0; lim_q <= '0; a_q <= '0;
      sect_err <= 1'b0; surf_err <= 1'b0; cyl_err <= 1'b0;
      lin_sector <= '0; end_of_pack <= 1'b0; xfer_cnt <= '0; next_addr <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        IDLE: if (start) begin
          a_q <= addr_in; lim_q <= lim_in;
          sect_err <= sect_c; surf_err <= surf_c; cyl_err <= cyl_c;
          lin_sector <= lin_c; end_of_pack <= eop_c; xfer_cnt <= xc_c;
          dvd <= fs_c; rem <= '0; stepc <= '0; phase <= DIV_TRK;
        end
        DIV_TRK: begin
          if (stepc == 5'(LINW - 1)) begin
            cyl_q <= dvd_n[CYLW-1:0];
            dvd   <= {rem_n, (LINW-RW)'(0)};
            rem   <= '0; stepc <= '0; phase <= DIV_SEC;
          end else begin
            dvd <= dvd_n; rem <= rem_n; stepc <= stepc + 5'd1;
          end
        end
        DIV_SEC: begin
          dvd <= dvd_n; rem <= rem_n; stepc <= stepc + 5'd1;
          if (stepc == 5'(RW - 1)) begin
            next_addr <= err_q ? a_q : {cyl_w[7:0], dvd_n[4:0], cyl_w[8], rem_n[3:0]};
            done  <= 1'b1;
            phase <= IDLE;
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(lin_sector) && $stable(xfer_cnt) && $stable(end_of_pack)));
  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_q) |-> (next_addr == a_q && xfer_cnt == '0 && !end_of_pack));
  assert_field_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_q) |-> (next_addr[3:0] < 4'(SECTS) && next_addr[9:5] < 5'(SURFS)));
  assert_cyl_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_q) |-> ({next_addr[4], next_addr[17:10]} < lim_q));
  assert_eop_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    end_of_pack |-> !err_q);
endmodule

// File: tb/disk_addr_stepper_bench.sv
module disk_addr_stepper_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, large_drive = 1'b0;
  logic [17:0] addr_in = '0, word_cnt = '0;
  logic busy, done, sect_err, surf_err, cyl_err, end_of_pack;
  logic [16:0] lin_sector;
  logic [17:0] xfer_cnt, next_addr;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  disk_addr_stepper u_disk_addr_stepper (
    .clk(clk), .rst_n(rst_n), .start(start), .large_drive(large_drive),
    .addr_in(addr_in), .word_cnt(word_cnt), .busy(busy), .done(done),
    .sect_err(sect_err), .surf_err(surf_err), .cyl_err(cyl_err),
    .lin_sector(lin_sector), .end_of_pack(end_of_pack),
    .xfer_cnt(xfer_cnt), .next_addr(next_addr));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] pk(input int cyl, input int surf, input int sect);
    return {8'(cyl), 5'(surf), 1'(cyl >> 8), 4'(sect)};
  endfunction

  task automatic model(input logic [17:0] a, input bit big, input logic [17:0] c,
                       output bit es, output bit ef, output bit ec, output longint lin,
                       output bit eop, output longint xc, output logic [17:0] nx,
                       output bit wrapped);
    longint sect = a[3:0], surf = a[9:5];
    longint cyl = longint'(a[17:10]) + (a[4] ? 256 : 0);
    longint lim = big ? 406 : 203;
    longint cap = lim * 200 * 256, sw, fs, fc, r;
    es = sect >= 10; ef = surf >= 20; ec = cyl >= lim;
    lin = (cyl * 20 + surf) * 10 + sect;
    sw = lin * 256; wrapped = 0;
    if (es || ef || ec) begin
      eop = 0; xc = 0; nx = a;
    end else begin
      eop = (sw + c) > cap;
      xc = eop ? cap - sw : longint'(c);
      fs = (sw + xc + 255) / 256;
      fc = fs / 200; r = fs % 200;
      if (fc >= lim) begin fc = 0; wrapped = 1; end
      nx = pk(int'(fc), int'(r / 10), int'(r % 10));
    end
  endtask

  task automatic run_op(input logic [17:0] a, input bit big, input logic [17:0] c,
                        input bit poke);
    bit es, ef, ec, eop, wr;
    longint lin, xc;
    logic [17:0] nx;
    int n = 0;
    string rq;
    model(a, big, c, es, ef, ec, lin, eop, xc, nx, wr);
    @(negedge clk);
    addr_in = a; large_drive = big; word_cnt = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    do begin
      if (poke && n == 3) begin
        addr_in = ~a; word_cnt = ~c; large_drive = ~big; start = 1'b1;
      end else start = 1'b0;
      @(posedge clk); n++;
      @(negedge clk);
    end while (!done && n < 100);
    start = 1'b0;
    chk(n == 25, "R10", "done latency", n, 25);
    chk(!busy, "R10", "busy after done", busy, 0);
    chk(sect_err == es, "R2", "sect_err", sect_err, es);
    chk(surf_err == ef, "R3", "surf_err", surf_err, ef);
    chk(cyl_err == ec, "R4", "cyl_err", cyl_err, ec);
    chk(lin_sector == 17'(lin), "R1 R5", "lin_sector", lin_sector, lin);
    chk(end_of_pack == eop, "R6", "end_of_pack", end_of_pack, eop);
    chk(xfer_cnt == 18'(xc), "R6", "xfer_cnt", xfer_cnt, xc);
    rq = (es || ef || ec) ? "R9" : (wr ? "R8" : "R7");
    if (poke) rq = {rq, " R11"};
    chk(next_addr == nx, rq, "next_addr", next_addr, nx);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
    chk(next_addr == nx, "R10", "next_addr held", next_addr, nx);
  endtask

  initial begin : watchdog
    #900000;
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R10", "reset busy/done", {busy, done}, 0);
    chk(next_addr == 0 && xfer_cnt == 0, "R10", "reset results", next_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(pk(0, 0, 0), 0, 18'd0, 0);
    run_op(pk(0, 0, 0), 0, 18'd1, 0);
    run_op(pk(0, 0, 0), 0, 18'd256, 0);
    run_op(pk(0, 0, 0), 0, 18'd257, 0);
    run_op(pk(5, 19, 9), 0, 18'd256, 0);
    run_op(pk(300, 7, 3), 1, 18'd5000, 0);
    run_op(pk(203, 0, 0), 0, 18'd10, 0);
    run_op(pk(203, 0, 0), 1, 18'd10, 0);
    run_op(pk(10, 0, 10), 0, 18'd10, 0);
    run_op(pk(10, 20, 0), 0, 18'd10, 0);
    run_op(pk(202, 19, 9), 0, 18'd256, 0);
    run_op(pk(202, 19, 9), 0, 18'd1000, 0);
    run_op(pk(405, 19, 0), 1, 18'd262143, 0);
    run_op(pk(255, 19, 9), 1, 18'd256, 0);
    run_op(pk(12, 4, 4), 0, 18'd700, 1);
    for (int i = 0; i < 300; i++) begin
      int mode = int'($urandom % 4);
      bit big = 1'($urandom);
      int lim = big ? 406 : 203;
      logic [17:0] a, c;
      c = (($urandom % 2) == 0) ? 18'($urandom) : 18'($urandom % 3000);
      if (mode == 0) a = 18'($urandom);
      else if (mode == 3)
        a = pk(lim - 1, int'($urandom % 20), int'($urandom % 10));
      else
        a = pk(int'($urandom % 32'(lim)), int'($urandom % 20), int'($urandom % 10));
      run_op(a, big, c, (i % 50) == 7);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule